// File: doc/BRIEF.md
# Video Memory Host Access Port

This block is the part of a video display controller that the host processor uses to reach video RAM. The host has two byte-wide entry points. Two strobes on the control entry load a memory address and choose whether the host will read or write. Strobes on the data entry then move one byte per strobe and step the address forward. Reads are never served straight from memory. A read-ahead buffer holds the byte at the current address, and the port refills that buffer by itself after a read-mode setup and after every data read.

The port may touch memory only when the display fetch engine leaves it an access slot. The spacing of those slots depends on the display mode. Busier modes leave fewer slots. At most one memory operation waits at a time. While one waits, the port raises `not_ready`. That output is the minimum spacing the host has to keep between accesses. A host that ignores it reads a stale buffer. If it writes again before the earlier write has gone out, the earlier write is lost and a sticky `overrun` flag is set.

Memory is made of three 64 KB banks. Each bank has its own one-hot strobe, and all three share the address and data lines. The port drives those strobes only in the cycle its slot is granted.

Top module: `vmp_host_port`

## Requirements
- R1: After reset, `not_ready`, `overrun`, `host_dout` and `mem_cas` are all zero.
- R2: Two `ctl_wr` strobes load the address. The first byte is the low offset byte. In the second byte, bits 5:0 become offset bits 13:8, offset bits 15:14 are cleared, bit 7 selects the expansion bank, and bit 6 selects write mode (1) or read mode (0). A read-mode setup prefetches the byte at the loaded address, and the first later data read returns that byte.
- R3: Each `data_rd` copies the buffered byte to `host_dout`, visible after the next clock edge. It then advances the offset by one and prefetches the byte at the new offset, so consecutive reads return consecutive bytes.
- R4: Each `data_wr` writes `host_din` to the current address and advances the offset by one.
- R5: Any data-port strobe makes the next `ctl_wr` byte count as a low byte, even if one control byte was already taken.
- R6: `mem_cas` is one-hot or zero. Bit 2 selects the expansion bank when bit 7 of the setup byte was 1. Otherwise bit 1 selects bank 1 when offset bit 15 is 1, and bit 0 selects bank 0 when it is 0. A strobe only appears while a request is pending.
- R7: `not_ready` rises in the cycle after a request is issued. It falls in the cycle after that request's slot. The wait lasts at most the slot period of the current `disp_mode`: 0, 1, 2 and 3 select `SLOT_P0` to `SLOT_P3`, which default to 2, 4, 7 and 12 cycles.
- R8: A data read made while a prefetch is still pending returns the buffer's earlier contents.
- R9: A data write made while an earlier write is still pending and not being served sets `overrun`. `overrun` then stays set until reset.
- R10: The offset increments across all 16 bits. Stepping from 0x3FFF continues at 0x4000, and stepping from 0x7FFF moves the strobe to bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_mode | input | 2 | Display mode, selects the slot period |
| ctl_wr | input | 1 | Control-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| host_din | input | 8 | Host write byte |
| host_dout | output | 8 | Byte returned by the last data read |
| not_ready | output | 1 | A memory request is waiting for its slot |
| overrun | output | 1 | Sticky: a pending write was overwritten |
| mem_cas | output | 3 | One-hot bank strobe during a granted slot |
| mem_we | output | 1 | Memory write enable during the slot |
| mem_addr | output | 16 | Offset within the bank |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, sampled in the slot |

## Verification
A wrong address latch or a wrong byte toggle shows up as a wrong byte on `host_dout` one cycle after the first read that follows setup. A wrong bank decode shows up the same way, because the memory pattern in the bench depends on the strobe. A broken slot timer or broken pending logic shows up as a `not_ready` pulse that is longer than the mode's period, or as a pulse with no strobe before it falls. Either is visible within one slot period. A pending request that is dropped or lost leaves `overrun` in the wrong state, or leaves a stale byte where a fresh one was due, at the next read.

// File: rtl/vmp_pkg.sv
// Shared widths, field positions, request record and bank decode for the
// video memory host port.
package vmp_pkg;
    localparam int BYTE_W   = 8;
    localparam int OFF_W    = 16;   // offset within one bank
    localparam int SET_HI_W = 6;    // offset bits loaded by the second control byte
    localparam int WE_BIT   = 6;    // second control byte: 1 = write mode
    localparam int EXT_BIT  = 7;    // second control byte: expansion bank
    localparam int BANKS    = 3;
    localparam int MODES    = 4;
    localparam int MODE_W   = $clog2(MODES);

    typedef struct packed {
        logic              we;
        logic              ext;
        logic [OFF_W-1:0]  off;
        logic [BYTE_W-1:0] data;
    } vmp_req_t;

    // One-hot bank strobe: expansion first, then offset MSB picks bank 1/0.
    function automatic logic [BANKS-1:0] bank_sel(input logic ext, input logic [OFF_W-1:0] off);
        logic [BANKS-1:0] s;
        s = '0;
        if (ext)             s[2] = 1'b1;
        else if (off[OFF_W-1]) s[1] = 1'b1;
        else                 s[0] = 1'b1;
        return s;
    endfunction
endpackage

// File: rtl/vmp_addr_unit.sv
// Address latch and control byte toggle.
// Assumes at most one host strobe per cycle; the top gives control priority.
// The second control byte loads the low offset bits and clears the rest;
// data accesses advance the offset and re-arm the toggle for a low byte.
module vmp_addr_unit
    import vmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              data_acc,
    input  logic [BYTE_W-1:0] din,
    output logic              second_q,
    output logic [BYTE_W-1:0] lo_q,
    output logic              ext_q,
    output logic [OFF_W-1:0]  off_q
);
    localparam int PAD_W = OFF_W - SET_HI_W - BYTE_W;

    // Track the byte pair, load the address, step it on data accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b0;
            lo_q     <= '0;
            ext_q    <= 1'b0;
            off_q    <= '0;
        end else if (ctl_wr) begin
            if (!second_q) begin
                lo_q     <= din;
                second_q <= 1'b1;
            end else begin
                second_q <= 1'b0;
                ext_q    <= din[EXT_BIT];
                off_q    <= {{PAD_W{1'b0}}, din[SET_HI_W-1:0], lo_q};
            end
        end else if (data_acc) begin
            second_q <= 1'b0;
            off_q    <= off_q + 1'b1;
        end
    end
endmodule

// File: rtl/vmp_slot_timer.sv
// Models the supply of CPU access slots left by the display fetch engine.
// A free-running down counter reloads with the period of the current mode;
// a mode change takes effect at the next reload.
module vmp_slot_timer
    import vmp_pkg::*;
#(
    parameter int P0 = 2,
    parameter int P1 = 4,
    parameter int P2 = 7,
    parameter int P3 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    output logic              tick
);
    localparam int PER [MODES] = '{P0, P1, P2, P3};
    localparam int MAXP  = (P0 > P1 ? P0 : P1) > (P2 > P3 ? P2 : P3) ?
                           (P0 > P1 ? P0 : P1) : (P2 > P3 ? P2 : P3);
    localparam int CNT_W = $clog2(MAXP + 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    // Count down to the next slot and reload from the mode table.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= CNT_W'(PER[mode] - 1);
        else           cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/vmp_req_unit.sv
// Single pending memory request, read-ahead buffer and overrun flag.
// A newly issued request replaces a pending one; a request served in the
// same cycle still completes. Only write-over-write counts as overrun.
module vmp_req_unit
    import vmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_v,
    input  vmp_req_t          issue,
    input  logic              tick,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              serve,
    output logic              pend_q,
    output vmp_req_t          req_q,
    output logic [BYTE_W-1:0] rd_buf_q,
    output logic              overrun_q
);
    assign serve = tick & pend_q;

    // Hold the request, fill the buffer on read slots, flag lost writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            req_q     <= '0;
            rd_buf_q  <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (serve && !req_q.we) rd_buf_q <= mem_rdata;
            if (issue_v) begin
                req_q  <= issue;
                pend_q <= 1'b1;
                if (issue.we && pend_q && req_q.we && !serve) overrun_q <= 1'b1;
            end else if (serve) begin
                pend_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/vmp_host_port.sv
// Host access port to video RAM: control/data byte ports, read-ahead,
// slot-paced memory requests and the not-ready spacing indication.
// Assumes the host raises at most one strobe per cycle; if several are
// raised, control wins over data write, and data write wins over data read.
module vmp_host_port
    import vmp_pkg::*;
#(
    parameter int SLOT_P0 = 2,
    parameter int SLOT_P1 = 4,
    parameter int SLOT_P2 = 7,
    parameter int SLOT_P3 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] disp_mode,
    input  logic              ctl_wr,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] host_din,
    output logic [BYTE_W-1:0] host_dout,
    output logic              not_ready,
    output logic              overrun,
    output logic [BANKS-1:0]  mem_cas,
    output logic              mem_we,
    output logic [OFF_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int PAD_W = OFF_W - SET_HI_W - BYTE_W;
    localparam int MAX_PERIOD =
        (SLOT_P0 > SLOT_P1 ? SLOT_P0 : SLOT_P1) > (SLOT_P2 > SLOT_P3 ? SLOT_P2 : SLOT_P3) ?
        (SLOT_P0 > SLOT_P1 ? SLOT_P0 : SLOT_P1) : (SLOT_P2 > SLOT_P3 ? SLOT_P2 : SLOT_P3);

    logic              do_wr, do_rd, data_acc;
    logic              second_q, ext_q;
    logic [BYTE_W-1:0] lo_q, rd_buf;
    logic [OFF_W-1:0]  off_q;
    logic              tick, serve, pend;
    logic              issue_v;
    vmp_req_t          issue, req;

    assign do_wr    = data_wr & ~ctl_wr;
    assign do_rd    = data_rd & ~ctl_wr & ~data_wr;
    assign data_acc = do_wr | do_rd;

    vmp_addr_unit u_addr (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_acc(data_acc),
        .din(host_din), .second_q(second_q), .lo_q(lo_q), .ext_q(ext_q), .off_q(off_q)
    );

    vmp_slot_timer #(.P0(SLOT_P0), .P1(SLOT_P1), .P2(SLOT_P2), .P3(SLOT_P3)) u_slot (
        .clk(clk), .rst_n(rst_n), .mode(disp_mode), .tick(tick)
    );

    // Build the memory request raised by this cycle's host strobe.
    always_comb begin
        issue_v = 1'b0;
        issue   = '0;
        if (ctl_wr) begin
            if (second_q && !host_din[WE_BIT]) begin
                issue_v   = 1'b1;
                issue.ext = host_din[EXT_BIT];
                issue.off = {{PAD_W{1'b0}}, host_din[SET_HI_W-1:0], lo_q};
            end
        end else if (do_wr) begin
            issue_v    = 1'b1;
            issue.we   = 1'b1;
            issue.ext  = ext_q;
            issue.off  = off_q;
            issue.data = host_din;
        end else if (do_rd) begin
            issue_v   = 1'b1;
            issue.ext = ext_q;
            issue.off = off_q + 1'b1;
        end
    end

    vmp_req_unit u_req (
        .clk(clk), .rst_n(rst_n), .issue_v(issue_v), .issue(issue), .tick(tick),
        .mem_rdata(mem_rdata), .serve(serve), .pend_q(pend), .req_q(req),
        .rd_buf_q(rd_buf), .overrun_q(overrun)
    );

    // Hand the buffered byte to the host on each data read.
    always_ff @(posedge clk) begin
        if (!rst_n)     host_dout <= '0;
        else if (do_rd) host_dout <= rd_buf;
    end

    assign not_ready = pend;
    assign mem_cas   = serve ? bank_sel(req.ext, req.off) : '0;
    assign mem_we    = serve & req.we;
    assign mem_addr  = req.off;
    assign mem_wdata = req.data;
endmodule

// File: rtl/vmp_host_port_chk.sv
// Port-level properties of the host port, attached by bind.
module vmp_host_port_chk #(
    parameter int MAXP = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic       data_wr,
    input logic       data_rd,
    input logic       not_ready,
    input logic       overrun,
    input logic [2:0] mem_cas
);
    localparam int BW = $clog2(MAXP + 2) + 1;
    logic [BW-1:0] busy_cnt;

    // Count not-ready cycles since the last host strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_wr || data_wr || data_rd || !not_ready) busy_cnt <= '0;
        else if (busy_cnt != '1) busy_cnt <= busy_cnt + 1'b1;
    end

    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mem_cas));
    a_r6_strobe_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_cas) |-> not_ready);
    a_r3_read_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !ctl_wr && !data_wr) |=> not_ready);
    a_r7_fall_after_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(not_ready) |-> $past(|mem_cas));
    a_r7_bounded_wait: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BW'(MAXP));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
endmodule

bind vmp_host_port vmp_host_port_chk #(.MAXP(MAX_PERIOD)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_wr(data_wr), .data_rd(data_rd),
    .not_ready(not_ready), .overrun(overrun), .mem_cas(mem_cas)
);

// File: tb/sim_vmp_host_port.sv
// Bench for vmp_host_port: directed corners plus seeded random traffic.
module sim_vmp_host_port;
    localparam int PER [4] = '{2, 4, 7, 12};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] disp_mode = '0;
    logic       ctl_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] host_din = '0, host_dout, mem_wdata, mem_rdata;
    logic       not_ready, overrun, mem_we;
    logic [2:0] mem_cas;
    logic [15:0] mem_addr;

    always #2 clk = ~clk;

    vmp_host_port u0 (
        .clk(clk), .rst_n(rst_n), .disp_mode(disp_mode), .ctl_wr(ctl_wr),
        .data_wr(data_wr), .data_rd(data_rd), .host_din(host_din), .host_dout(host_dout),
        .not_ready(not_ready), .overrun(overrun), .mem_cas(mem_cas), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_bad = 0, wr_cnt = 0;
    bit done = 0;
    logic [7:0] wmem [int];
    logic [7:0] expw [int];
    logic        m_ext;
    logic [15:0] m_off;

    function automatic int key(logic [2:0] c, logic [15:0] a);
        return int'({13'd0, c, a});
    endfunction
    function automatic logic [7:0] pat(logic [2:0] c, logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ {c, 5'd0} ^ 8'h5A;
    endfunction
    function automatic logic [2:0] exp_bank(logic e, logic [15:0] a);
        return e ? 3'b100 : (a[15] ? 3'b010 : 3'b001);
    endfunction
    function automatic logic [7:0] exp_byte(logic e, logic [15:0] a);
        int k;
        k = key(exp_bank(e, a), a);
        return expw.exists(k) ? expw[k] : pat(exp_bank(e, a), a);
    endfunction

    // Memory model: pattern unless written.
    always @(mem_cas or mem_addr or wr_cnt) begin
        if (wmem.exists(key(mem_cas, mem_addr))) mem_rdata = wmem[key(mem_cas, mem_addr)];
        else mem_rdata = pat(mem_cas, mem_addr);
    end
    always @(posedge clk) begin
        if (|mem_cas && mem_we) begin
            wmem[key(mem_cas, mem_addr)] = mem_wdata;
            wr_cnt = wr_cnt + 1;
        end
    end

    task automatic chk(bit ok, string tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (not_ready) @(negedge clk);
    endtask

    task automatic ctl(logic [7:0] b);
        @(negedge clk); ctl_wr = 1'b1; host_din = b;
        @(posedge clk); #1 ctl_wr = 1'b0;
    endtask

    task automatic setup(logic [13:0] a, logic e, logic we);
        wait_ready();
        ctl(a[7:0]);
        ctl({e, we, a[13:8]});
        m_ext = e; m_off = {2'b00, a};
    endtask

    task automatic rd_get(output logic [7:0] v);
        wait_ready();
        data_rd = 1'b1;
        @(posedge clk); #1 data_rd = 1'b0;
        @(negedge clk); v = host_dout;
    endtask

    task automatic rd_check(string tag);
        logic [7:0] v, e;
        e = exp_byte(m_ext, m_off);
        rd_get(v);
        chk(v == e, tag, v, e);
        m_off = m_off + 1;
    endtask

    task automatic wr(logic [7:0] b);
        wait_ready();
        data_wr = 1'b1; host_din = b;
        @(posedge clk); #1 data_wr = 1'b0;
        expw[key(exp_bank(m_ext, m_off), m_off)] = b;
        m_off = m_off + 1;
    endtask

    task automatic set_mode(logic [1:0] m);
        wait_ready();
        disp_mode = m;
        repeat (14) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        logic [7:0] v, e;
        int errs, busy;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(not_ready == 0, "R1 not_ready", not_ready, 0);
        chk(overrun == 0, "R1 overrun", overrun, 0);
        chk(host_dout == 0, "R1 host_dout", host_dout, 0);
        chk(mem_cas == 0, "R1 mem_cas", mem_cas, 0);

        // R2 address setup then first read, R3 sequential reads
        set_mode(2'd1);
        setup(14'h0123, 1'b0, 1'b0);
        rd_check("R2 first read");
        rd_check("R3 seq read 1");
        rd_check("R3 seq read 2");
        rd_check("R3 seq read 3");

        // R6 expansion bank write and readback; R4 writes
        setup(14'h0040, 1'b1, 1'b0);
        rd_check("R6 expansion read");
        setup(14'h0040, 1'b1, 1'b1);
        wr(8'hC3); wr(8'h3C);
        setup(14'h0040, 1'b1, 1'b0);
        rd_check("R4 R6 expansion write 0");
        rd_check("R4 R6 expansion write 1");
        setup(14'h0040, 1'b0, 1'b0);
        rd_check("R6 bank0 untouched");

        // R5 data access re-arms the byte toggle
        ctl(8'hEE);
        rd_get(v);
        setup(14'h0210, 1'b0, 1'b0);
        rd_check("R5 toggle reset");

        // R8 stale read while prefetch pending
        set_mode(2'd3);
        setup(14'h0500, 1'b0, 1'b0);
        e = exp_byte(1'b0, 16'h0500);
        rd_get(v);
        chk(v == e, "R8 first read", v, e);
        e = not_ready ? exp_byte(1'b0, 16'h0500) : exp_byte(1'b0, 16'h0501);
        data_rd = 1'b1;
        @(posedge clk); #1 data_rd = 1'b0;
        @(negedge clk);
        chk(host_dout == e, "R8 stale buffer", host_dout, e);
        m_off = 16'h0502;
        rd_check("R8 after stale");

        // R7 slot wait bound per mode
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            setup(14'h0777, 1'b0, 1'b0);
            busy = 0;
            @(negedge clk);
            while (not_ready) begin busy++; @(negedge clk); end
            chk(busy >= 1 && busy <= PER[m], "R7 wait within period", busy, PER[m]);
        end

        // R10 carry through 0x4000 and into bank 1
        set_mode(2'd0);
        setup(14'h3FFE, 1'b0, 1'b0);
        errs = 0;
        while (m_off != 16'h8002) begin
            e = exp_byte(1'b0, m_off);
            rd_get(v);
            if (v != e) errs++;
            if (m_off == 16'h4000) chk(v == e, "R10 carry to 0x4000", v, e);
            if (m_off == 16'h8000) chk(v == e, "R10 R6 bank1 at 0x8000", v, e);
            m_off = m_off + 1;
        end
        chk(errs == 0, "R10 climb errors", errs, 0);

        // Random traffic: R4 writes then R3 readback under random modes
        for (int it = 0; it < 30; it++) begin
            logic [13:0] a;
            logic        x;
            int          n;
            set_mode(2'($urandom_range(0, 3)));
            a = 14'($urandom_range(0, 16'h3FFF));
            x = 1'($urandom_range(0, 1));
            n = $urandom_range(1, 4);
            setup(a, x, 1'b1);
            for (int i = 0; i < n; i++) wr(8'($urandom));
            setup(a, x, 1'b0);
            for (int i = 0; i < n; i++) rd_check("R4 R3 random readback");
        end

        // R9 overrun on back-to-back writes, sticky afterwards
        set_mode(2'd3);
        setup(14'h1000, 1'b0, 1'b1);
        chk(overrun == 0, "R9 clear before", overrun, 0);
        wait_ready();
        data_wr = 1'b1; host_din = 8'h11;
        repeat (3) @(posedge clk);
        #1 data_wr = 1'b0;
        @(negedge clk);
        chk(overrun == 1, "R9 overrun set", overrun, 1);
        setup(14'h0123, 1'b0, 1'b0);
        rd_get(v);
        @(negedge clk);
        chk(overrun == 1, "R9 overrun sticky", overrun, 1);

        summary();
    end
endmodule